// File: doc/BRIEF.md
# Split-Read 64-Bit System Timer

This block is a free-running system timer whose count is read over a 32-bit synchronous register bus as two halves. A read of the low half also copies the upper half into a separate snapshot register in the same clock cycle. Software reads the low half first and then the snapshot, and gets a consistent 64-bit value even if the low half wraps between the two accesses.

Counting is gated by an enable flag and by a count-tick input. The enable flag is set and cleared through a write-one-to-set and write-one-to-clear register pair. A 32-bit compare register drives a sticky match flag. A mode bit selects what happens at a compare match: the counter either keeps running past the compare value or returns to zero. A build parameter selects a narrow 32-bit variant instead. In that variant the whole count sits in the low-count register, and the high and snapshot registers do not exist.

Bus reads are registered, so read data appears on `rd_data` one clock after the read is presented. Register byte offsets: control 0x00, compare 0x04, low count 0x08, high count 0x0C, snapshot 0x10, enable-set 0x14, enable-clear 0x18.

Top module: `sys_timer_split`

## Requirements
- R1: After reset both count halves, the snapshot and `rd_data` are zero, the timer is stopped, the mode bit and match flag are zero, and compare holds 0xFFFFFFFF.
- R2: Writing a word with bit 15 set to 0x14 starts the timer, and writing a word with bit 15 set to 0x18 stops it. A write with bit 15 clear has no effect. Control bit 0 reads 1 while the timer runs.
- R3: The count rises by exactly one on each clock edge at which the timer runs and `tick` is high, and holds otherwise.
- R4: In the 64-bit build, a carry out of the low 32 bits increments the high half at the same edge.
- R5: A read of 0x08 copies the high half into the snapshot register (0x10) at that edge. Later reads of 0x10 return that copy while the high half moves on.
- R6: Every read of 0x08 overwrites the snapshot with the high half current at that read.
- R7: With control bit 15 set to 1, the counter counts through the compare value without restarting.
- R8: With control bit 15 at 0, a counting edge at which the low half equals compare clears both halves to zero.
- R9: Control bit 1 is a sticky flag. It is set in every cycle in which the timer runs and the low half equals compare. Writing 1 to bit 1 of 0x00 clears it; writing 0 leaves it set.
- R10: A bus write to a count half takes priority over an increment at the same edge. A low-half write suppresses the carry.
- R11: Offsets outside the map, and the enable-set and enable-clear registers, read as zero. Writes to the snapshot register are ignored.
- R12: With WIDE_COUNT=0 the count is 32 bits in 0x08 and wraps to zero. 0x0C and 0x10 read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count-enable pulse |
| bus_sel | input | 1 | Bus access valid |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |

## Verification
The assertions assume that the bus presents at most one access per cycle and that `tick` and bus signals change only away from the rising edge. The carry and restart properties also assume that no count write arrives in the same cycle. The stimulus drives every input on the falling edge and clears `bus_sel` after each access. It places count writes with `tick` high only in the steps that test write priority. The carry and restart properties therefore see only the cycle shapes they describe.

// File: rtl/sys_timer_split.sv
module sys_timer_split #(
  parameter bit WIDE_COUNT = 1'b1,
  parameter int MODE_BIT   = 15,
  parameter int START_BIT  = 15
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [4:0]  bus_addr,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data
);
  localparam logic [4:0] OFS_CTRL = 5'h00;
  localparam logic [4:0] OFS_CMP  = 5'h04;
  localparam logic [4:0] OFS_LO   = 5'h08;
  localparam logic [4:0] OFS_HI   = 5'h0C;
  localparam logic [4:0] OFS_SNAP = 5'h10;
  localparam logic [4:0] OFS_SET  = 5'h14;
  localparam logic [4:0] OFS_CLR  = 5'h18;

  logic [31:0] lo_q, hi_q, snap_q, cmp_q, rd_val;
  logic        run_q, keep_q, flag_q;

  wire is_wr   = bus_sel & bus_wr;
  wire is_rd   = bus_sel & ~bus_wr;
  wire wr_ctrl = is_wr & (bus_addr == OFS_CTRL);
  wire wr_cmp  = is_wr & (bus_addr == OFS_CMP);
  wire wr_lo   = is_wr & (bus_addr == OFS_LO);
  wire wr_hi   = is_wr & (bus_addr == OFS_HI) & WIDE_COUNT;
  wire rd_lo   = is_rd & (bus_addr == OFS_LO);
  wire go      = is_wr & (bus_addr == OFS_SET) & wr_data[START_BIT];
  wire halt    = is_wr & (bus_addr == OFS_CLR) & wr_data[START_BIT];

  wire step    = run_q & tick;
  wire hit     = run_q & (lo_q == cmp_q);
  wire restart = step & hit & ~keep_q;
  wire [32:0] lo_inc = {1'b0, lo_q} + 33'd1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       lo_q <= '0;
    else if (wr_lo)   lo_q <= wr_data;
    else if (restart) lo_q <= '0;
    else if (step)    lo_q <= lo_inc[31:0];

  generate
    if (WIDE_COUNT) begin : g_wide
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)                          hi_q <= '0;
        else if (wr_hi)                      hi_q <= wr_data;
        else if (restart & ~wr_lo)           hi_q <= '0;
        else if (step & lo_inc[32] & ~wr_lo) hi_q <= hi_q + 32'd1;

      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)     snap_q <= '0;
        else if (rd_lo) snap_q <= hi_q;

      AST_CARRY_INTO_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (step && lo_q == 32'hFFFF_FFFF && (keep_q || lo_q != cmp_q) && !wr_lo && !wr_hi)
        |=> hi_q == $past(hi_q) + 32'd1); // R4
      AST_SNAP_TAKES_HI: assert property (@(posedge clk) disable iff (!rst_n)
        rd_lo |=> snap_q == $past(hi_q)); // R5
      AST_SNAP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_lo |=> $stable(snap_q)); // R6
    end else begin : g_narrow
      assign hi_q   = '0;
      assign snap_q = '0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cmp_q  <= '1;
      keep_q <= 1'b0;
      flag_q <= 1'b0;
      run_q  <= 1'b0;
    end else begin
      if (wr_cmp)  cmp_q  <= wr_data;
      if (wr_ctrl) keep_q <= wr_data[MODE_BIT];
      flag_q <= hit | (flag_q & ~(wr_ctrl & wr_data[1]));
      if (go)        run_q <= 1'b1;
      else if (halt) run_q <= 1'b0;
    end

  always_comb begin
    rd_val = '0;
    case (bus_addr)
      OFS_CTRL: begin
        rd_val[MODE_BIT] = keep_q;
        rd_val[1]        = flag_q;
        rd_val[0]        = run_q;
      end
      OFS_CMP:  rd_val = cmp_q;
      OFS_LO:   rd_val = lo_q;
      OFS_HI:   rd_val = hi_q;
      OFS_SNAP: rd_val = snap_q;
      default:  rd_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rd_data <= '0;
    else        rd_data <= is_rd ? rd_val : 32'd0;

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !wr_lo) |=> $stable(lo_q)); // R3
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !restart && !wr_lo) |=> lo_q == $past(lo_q) + 32'd1); // R3
  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && !wr_lo) |=> lo_q == 32'd0); // R8
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !(wr_ctrl && wr_data[1])) |=> flag_q); // R9
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> lo_q == $past(wr_data)); // R10
  AST_HALT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> !run_q); // R2
endmodule

// File: tb/tb_sys_timer_split.sv
module tb_sys_timer_split;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, bus_sel = 1'b0, bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rdw, rdn;
  int nchk = 0, nerr = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sys_timer_split #(.WIDE_COUNT(1'b1)) dut (.clk(clk), .rst_n(rst_n), .tick(tick),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .wr_data(wr_data), .rd_data(rdw));
  sys_timer_split #(.WIDE_COUNT(1'b0)) dut_n (.clk(clk), .rst_n(rst_n), .tick(tick),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .wr_data(wr_data), .rd_data(rdn));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d, input logic t = 1'b0);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; wr_data = d; tick = t;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_wr = 1'b0; tick = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] w, output logic [31:0] n);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(posedge clk); #1;
    w = rdw; n = rdn;
    bus_sel = 1'b0;
  endtask

  task automatic run(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(posedge clk);
    #1 tick = 1'b0;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    logic [31:0] w, n;
    logic [63:0] s;
    repeat (3) @(posedge clk);
    #1 chk("R1 rd_data", rdw, 32'd0);
    @(negedge clk) rst_n = 1'b1;

    rd(5'h00, w, n); chk("R1 ctrl", w, 0); chk("R1 ctrl narrow", n, 0);
    rd(5'h04, w, n); chk("R1 cmp", w, 32'hFFFF_FFFF);
    rd(5'h08, w, n); chk("R1 lo", w, 0);
    rd(5'h0C, w, n); chk("R1 hi", w, 0);
    rd(5'h10, w, n); chk("R1 snap", w, 0);

    wr(5'h10, 32'd5); rd(5'h10, w, n); chk("R11 snap write ignored", w, 0);
    wr(5'h1C, 32'hABCD); rd(5'h1C, w, n); chk("R11 undefined", w, 0);
    rd(5'h14, w, n); chk("R11 set reads zero", w, 0);
    rd(5'h18, w, n); chk("R11 clr reads zero", w, 0);

    run(5); rd(5'h08, w, n); chk("R3 stopped holds", w, 0);
    wr(5'h14, 32'h7FFF); rd(5'h00, w, n); chk("R2 set without bit15", w, 0);
    wr(5'h14, 32'h8000); rd(5'h00, w, n); chk("R2 running", w, 32'h1);
    run(7); rd(5'h08, w, n); chk("R3 seven ticks", w, 7); chk("R3 narrow", n, 7);
    rd(5'h08, w, n); chk("R3 no tick holds", w, 7);
    wr(5'h00, 32'h8000); rd(5'h00, w, n); chk("R7 mode bit", w, 32'h8001);

    for (int i = 0; i < 8; i++) begin
      logic [31:0] hi0, lo0;
      hi0 = i * 5 + 1; lo0 = 32'hFFFF_FFFF - i;
      wr(5'h0C, hi0); wr(5'h08, lo0);
      run(i + 3);
      s = {hi0, lo0} + 64'(i + 3);
      rd(5'h08, w, n); chk("R4 sweep lo", w, s[31:0]); chk("R12 sweep narrow", n, s[31:0]);
      rd(5'h10, w, n); chk("R4 sweep hi via snapshot", w, s[63:32]);
    end

    wr(5'h0C, 32'h10); wr(5'h08, 32'hFFFF_FFFE);
    rd(5'h08, w, n);
    run(4);
    rd(5'h10, w, n); chk("R5 snapshot kept", w, 32'h10);
    rd(5'h0C, w, n); chk("R5 live hi moved", w, 32'h11);
    rd(5'h08, w, n); chk("R5 lo after wrap", w, 32'h2);
    rd(5'h10, w, n); chk("R6 snapshot overwritten", w, 32'h11);

    wr(5'h18, 32'h8000); rd(5'h00, w, n); chk("R2 stopped", w & 32'h1, 0);
    run(5); rd(5'h08, w, n); chk("R2 stopped holds", w, 32'h2);

    wr(5'h04, 32'd20); wr(5'h08, 32'd15); wr(5'h0C, 32'd0); wr(5'h00, 32'h8002);
    wr(5'h14, 32'h8000);
    run(10);
    rd(5'h08, w, n); chk("R7 free run past compare", w, 32'd25); chk("R7 narrow", n, 32'd25);
    rd(5'h00, w, n); chk("R9 flag set", w, 32'h8003);
    wr(5'h00, 32'h8000); rd(5'h00, w, n); chk("R9 write 0 keeps flag", w, 32'h8003);
    wr(5'h00, 32'h8002); rd(5'h00, w, n); chk("R9 flag cleared", w, 32'h8001);

    wr(5'h00, 32'h0002); wr(5'h0C, 32'd7); wr(5'h08, 32'd15);
    run(13);
    rd(5'h08, w, n); chk("R8 restart lo", w, 32'd7); chk("R8 narrow", n, 32'd7);
    rd(5'h0C, w, n); chk("R8 restart hi", w, 32'd0);
    rd(5'h00, w, n); chk("R9 flag at match", w, 32'h0003);

    wr(5'h08, 32'd100, 1'b1);
    rd(5'h08, w, n); chk("R10 lo write wins", w, 32'd100); chk("R10 narrow", n, 32'd100);
    wr(5'h0C, 32'h55, 1'b1);
    rd(5'h08, w, n); chk("R10 lo still counts", w, 32'd101);
    rd(5'h10, w, n); chk("R10 hi write wins", w, 32'h55); chk("R12 snap narrow", n, 0);
    rd(5'h0C, w, n); chk("R12 hi narrow", n, 0);

    wr(5'h08, 32'hFFFF_FFFE); run(3);
    rd(5'h08, w, n); chk("R12 narrow wraps", n, 32'd1); chk("R4 wide lo", w, 32'd1);
    rd(5'h0C, w, n); chk("R4 wide carry", w, 32'h56);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule